// File: doc/BRIEF.md
# Down-Counting System Tick Timer

A periodic 24-bit down-counter that produces a regular time base for an operating system or a polling loop. Software programs a reload value, turns the timer on, and then either polls a sticky status flag or takes a one-cycle interrupt request each time the count runs out. The counter always follows the same order of events. Turning it on loads the reload value. It then decrements once per step. The step that moves it from 1 to 0 is the wrap event. The step after that reloads it. A reload value of N therefore gives one event every N+1 steps.

Each step is either one core clock cycle or one cycle on which a reference tick strobe is high. A control bit makes this choice and is applied cycle by cycle. Software reaches three word registers through a synchronous port. Word address 0 is control/status, 1 is the reload value and 2 is the current count. Read data appears on the cycle after the read request.

Top module: `tick_timer`

## Requirements
- R1: The control/status word holds the run bit at bit 0, the interrupt-enable bit at bit 1, the clock-source bit at bit 2 and the sticky wrap flag at bit 16; every other bit reads 0, and a read of word address 3 returns 0. Read data is registered and appears the cycle after the request.
- R2: A control write that changes the run bit from 0 to 1 loads the reload value into the count on that edge; decrementing starts on the next step.
- R3: On the step where the count goes from 1 to 0 the wrap flag is set; on the next step the count reloads, giving a period of reload+1 steps.
- R4: When interrupt-enable is 0, a wrap sets the flag but never raises the interrupt request.
- R5: A read of the control/status word returns the flag and clears it.
- R6: With clock-source 1 the count steps on every core clock; with clock-source 0 it steps only on cycles where the reference tick strobe is high.
- R7: The reload register keeps bits [23:0] of a write; bits [31:24] are dropped and read as 0.
- R8: While the run bit is 0 the count holds its value and no flag or interrupt event occurs.
- R9: Any write to the current-count word clears the count to 0 and clears the flag, with no interrupt.
- R10: With a reload value of 0 the count stays at 0 after it reaches zero and produces no further wrap events.
- R11: The interrupt request is a single-cycle pulse that rises on the edge where the count becomes 0; a control read in the same cycle as a wrap returns the flag as 1 and leaves it set.
- R12: The synchronous active-low reset clears all registers and the count, and holds the interrupt request low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | Reference step strobe, one cycle wide, already synchronous to clk |
| addr | input | 2 | Word address: 0 control/status, 1 reload, 2 current count |
| wr_en | input | 1 | Write request for the addressed word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request for the addressed word |
| rd_data | output | 32 | Read data, valid the cycle after rd_en, 0 when no read was requested |
| irq | output | 1 | One-cycle interrupt request at each enabled wrap |

## Verification
The assertions assume that a write and a read never target the same word in the same cycle, and that the reference strobe changes only between clock edges. The bench drives every request at the falling edge and issues one register access at a time. It also pulses the reference strobe for single cycles only, so both assumptions hold. Because of these assumptions, the checker can treat the load, clear and step conditions as mutually ordered events.

// File: rtl/tick_pkg.sv
// Shared constants and the register word map of the tick timer.
// Assumes a 32-bit register word and a 2-bit word address.
package tick_pkg;
    localparam int DATA_W   = 32;
    localparam int CNT_W    = 24;
    localparam int ADDR_W   = 2;

    // Control/status field positions (fixed, software decodes them)
    localparam int EN_BIT   = 0;
    localparam int IE_BIT   = 1;
    localparam int SRC_BIT  = 2;
    localparam int FLAG_BIT = 16;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL    = 2'd0,
        SEL_RELOAD  = 2'd1,
        SEL_CURRENT = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tick_regfile.sv
// Holds the writable control bits and the reload value, and decodes the
// write strobes that start a load or clear the count.
// Assumes at most one access per cycle on the register port.
module tick_regfile
    import tick_pkg::*;
#(
    parameter int P_DATA_W = DATA_W,
    parameter int P_CNT_W  = CNT_W,
    parameter int P_ADDR_W = ADDR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [P_ADDR_W-1:0] addr,
    input  logic                wr_en,
    input  logic [P_DATA_W-1:0] wr_data,
    output logic                run_en,
    output logic                irq_en,
    output logic                core_src,
    output logic [P_CNT_W-1:0]  reload_val,
    output logic                start_load,
    output logic                cur_clear
);
    logic wr_ctrl;
    logic wr_reload;

    // Purpose: decode which word a write targets and the derived pulses.
    always_comb begin
        wr_ctrl    = wr_en && (addr == P_ADDR_W'(SEL_CTRL));
        wr_reload  = wr_en && (addr == P_ADDR_W'(SEL_RELOAD));
        cur_clear  = wr_en && (addr == P_ADDR_W'(SEL_CURRENT));
        start_load = wr_ctrl && wr_data[EN_BIT] && !run_en;
    end

    // Purpose: store the control bits and the low bits of the reload word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en     <= 1'b0;
            irq_en     <= 1'b0;
            core_src   <= 1'b0;
            reload_val <= '0;
        end else begin
            if (wr_ctrl) begin
                run_en   <= wr_data[EN_BIT];
                irq_en   <= wr_data[IE_BIT];
                core_src <= wr_data[SRC_BIT];
            end
            if (wr_reload) begin
                reload_val <= wr_data[P_CNT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/tick_down_counter.sv
// The down-counter: loads on start, steps when running, wraps 1 -> 0,
// reloads on the step after zero. A clear forces the count to 0.
// Assumes start_load and cur_clear are never high together.
module tick_down_counter #(
    parameter int P_CNT_W = tick_pkg::CNT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic               step,
    input  logic               start_load,
    input  logic               cur_clear,
    input  logic [P_CNT_W-1:0] reload_val,
    output logic [P_CNT_W-1:0] count,
    output logic               wrap
);
    localparam logic [P_CNT_W-1:0] ONE = P_CNT_W'(1);

    logic advance;

    // Purpose: decide whether this edge is a counting step and a wrap.
    always_comb begin
        advance = run_en && step && !start_load && !cur_clear;
        wrap    = advance && (count == ONE);
    end

    // Purpose: update the count in load / clear / step priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (cur_clear) begin
            count <= '0;
        end else if (start_load) begin
            count <= reload_val;
        end else if (advance) begin
            if (count == '0) begin
                count <= reload_val;
            end else begin
                count <= count - ONE;
            end
        end
    end
endmodule

// File: rtl/tick_event.sv
// Sticky wrap flag with read-to-clear, and the one-cycle interrupt pulse.
// Assumes wrap is already suppressed on cycles that clear the count.
module tick_event (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic irq_en,
    input  logic ctrl_rd,
    input  logic cur_clear,
    output logic flag,
    output logic irq
);
    // Purpose: set the flag on wrap, otherwise clear it on read or count clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (wrap) begin
            flag <= 1'b1;
        end else if (ctrl_rd || cur_clear) begin
            flag <= 1'b0;
        end
    end

    // Purpose: register a single-cycle request for each enabled wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= wrap && irq_en;
        end
    end
endmodule

// File: rtl/tick_timer.sv
// Top of the tick timer: register file, counter, event logic and the
// registered read port. Assumes ref_tick is synchronous and one cycle wide.
module tick_timer
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic             run_en;
    logic             irq_en;
    logic             core_src;
    logic [CNT_W-1:0] reload_val;
    logic             start_load;
    logic             cur_clear;
    logic [CNT_W-1:0] count;
    logic             wrap;
    logic             flag;
    logic             step;
    logic             ctrl_rd;
    logic [DATA_W-1:0] ctrl_word;

    tick_regfile #(
        .P_DATA_W(DATA_W), .P_CNT_W(CNT_W), .P_ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .run_en(run_en), .irq_en(irq_en),
        .core_src(core_src), .reload_val(reload_val),
        .start_load(start_load), .cur_clear(cur_clear)
    );

    // Purpose: pick the counting step source each cycle.
    always_comb begin
        step    = core_src || ref_tick;
        ctrl_rd = rd_en && (addr == ADDR_W'(SEL_CTRL));
    end

    tick_down_counter #(.P_CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .step(step),
        .start_load(start_load), .cur_clear(cur_clear),
        .reload_val(reload_val), .count(count), .wrap(wrap)
    );

    tick_event u_evt (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .irq_en(irq_en),
        .ctrl_rd(ctrl_rd), .cur_clear(cur_clear), .flag(flag), .irq(irq)
    );

    // Purpose: assemble the control/status word; a same-cycle wrap reads as set.
    always_comb begin
        ctrl_word           = '0;
        ctrl_word[EN_BIT]   = run_en;
        ctrl_word[IE_BIT]   = irq_en;
        ctrl_word[SRC_BIT]  = core_src;
        ctrl_word[FLAG_BIT] = flag || wrap;
    end

    // Purpose: register the selected word on a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (addr)
                ADDR_W'(SEL_CTRL):    rd_data <= ctrl_word;
                ADDR_W'(SEL_RELOAD):  rd_data <= DATA_W'(reload_val);
                ADDR_W'(SEL_CURRENT): rd_data <= DATA_W'(count);
                default:              rd_data <= '0;
            endcase
        end else begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
// Property checker for tick_timer, attached by bind. Assumes one register
// access per cycle and a reference strobe stable around clock edges.
module tick_timer_chk
    import tick_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              irq,
    input  logic              run_en,
    input  logic              irq_en,
    input  logic [CNT_W-1:0]  count,
    input  logic [CNT_W-1:0]  reload_val,
    input  logic              wrap,
    input  logic              flag,
    input  logic              start_load,
    input  logic              cur_clear
);
    // R1: reserved control bits read as zero
    a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(SEL_CTRL)) |=>
        (rd_data[DATA_W-1:FLAG_BIT+1] == '0 && rd_data[FLAG_BIT-1:SRC_BIT+1] == '0));

    // R7: reload word upper bits read as zero
    a_r7_reload_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(SEL_RELOAD)) |=> (rd_data[DATA_W-1:CNT_W] == '0));

    // R2: enabling loads the reload value
    a_r2_load_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
        start_load |=> (count == $past(reload_val)));

    // R3: a wrap leaves the flag set
    a_r3_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> flag);

    // R4: masked wraps raise no request
    a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !irq_en) |=> !irq);

    // R11: request is one cycle wide and coincides with a zero count
    a_r11_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    a_r11_irq_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count == '0));

    // R8: a stopped counter holds its value
    a_r8_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !start_load && !cur_clear) |=> $stable(count));

    // R9: clearing the count clears the flag without a request
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cur_clear |=> (count == '0 && !flag && !irq));

    // R10: zero reload keeps the count at zero
    a_r10_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && reload_val == '0) |=> (count == '0));
endmodule

bind tick_timer tick_timer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
    .irq(irq), .run_en(run_en), .irq_en(irq_en), .count(count),
    .reload_val(reload_val), .wrap(wrap), .flag(flag),
    .start_load(start_load), .cur_clear(cur_clear)
);

// File: tb/tb_tick_timer.sv
// Self-checking bench for tick_timer: a vector table of reload/wait/count
// cases, then directed tests for the flag, the request and corner cases.
module tb_tick_timer;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_RLD  = 2'd1;
    localparam logic [1:0] A_CUR  = 2'd2;
    localparam logic [1:0] A_NONE = 2'd3;
    localparam int NVEC = 9;
    localparam int V_RELOAD [NVEC] = '{10, 10, 10, 10, 10, 5, 1, 1, 200};
    localparam int V_WAIT   [NVEC] = '{0, 3, 10, 11, 15, 6, 1, 2, 57};

    logic        clk = 1'b0;
    logic        rst_n;
    logic        ref_tick;
    logic [1:0]  addr;
    logic        wr_en;
    logic [31:0] wr_data;
    logic        rd_en;
    logic [31:0] rd_data;
    logic        irq;
    int checks = 0;
    int errors = 0;

    tick_timer dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .addr(addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .irq(irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [31:0] v);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic int exp_count(input int r, input int k);
        return r - (k % (r + 1));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; ref_tick = 1'b0; addr = '0; wr_en = 1'b0;
        wr_data = '0; rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        check("R12 irq", {31'd0, irq}, 32'd0);
        do_read(A_CTRL, v); check("R12 ctrl", v, 32'd0);
        do_read(A_RLD, v);  check("R12 reload", v, 32'd0);
        do_read(A_CUR, v);  check("R12 current", v, 32'd0);

        // R1: layout, reserved bits and unused address
        do_write(A_CTRL, 32'hFFFF_FFFF);
        do_read(A_CTRL, v); check("R1 ctrl layout", v, 32'h0000_0007);
        do_read(A_NONE, v); check("R1 unused word", v, 32'd0);
        do_write(A_CTRL, 32'd0);

        // R7: reload keeps only 24 bits
        do_write(A_RLD, 32'hFFAB_CDEF);
        do_read(A_RLD, v); check("R7 reload mask", v, 32'h00AB_CDEF);

        // R2 R3 R6: vector table on the core clock
        for (int i = 0; i < NVEC; i++) begin
            do_write(A_CTRL, 32'd0);
            do_write(A_CUR, 32'd0);
            do_write(A_RLD, 32'(V_RELOAD[i]));
            do_write(A_CTRL, 32'h5);
            repeat (V_WAIT[i]) @(negedge clk);
            do_read(A_CUR, v);
            check($sformatf("R2/R3 vec%0d count", i), v, 32'(exp_count(V_RELOAD[i], V_WAIT[i])));
        end

        // R11 R3: enabled request pulses every 4 cycles for reload 3
        do_write(A_CTRL, 32'd0);
        do_write(A_CUR, 32'd0);
        do_write(A_RLD, 32'd3);
        do_write(A_CTRL, 32'h7);
        for (int i = 1; i <= 8; i++) begin
            check($sformatf("R11 irq cycle %0d", i), {31'd0, irq}, (i == 4 || i == 8) ? 32'd1 : 32'd0);
            @(negedge clk);
        end
        do_write(A_CTRL, 32'h6);
        // R5: read returns the flag, then it is cleared
        do_read(A_CTRL, v); check("R5 flag set", v, 32'h0001_0006);
        do_read(A_CTRL, v); check("R5 flag cleared", v, 32'h0000_0006);

        // R4: masked wraps set the flag only
        do_write(A_CUR, 32'd0);
        do_write(A_CTRL, 32'h5);
        for (int i = 1; i <= 8; i++) begin
            check("R4 no irq", {31'd0, irq}, 32'd0);
            @(negedge clk);
        end
        do_write(A_CTRL, 32'h4);
        do_read(A_CTRL, v); check("R4 flag without irq", v, 32'h0001_0004);

        // R9: count write clears count and flag
        do_write(A_CTRL, 32'h5);
        repeat (8) @(negedge clk);
        do_write(A_CTRL, 32'h4);
        do_write(A_CUR, 32'h0000_0123);
        check("R9 no irq", {31'd0, irq}, 32'd0);
        do_read(A_CUR, v);  check("R9 count cleared", v, 32'd0);
        do_read(A_CTRL, v); check("R9 flag cleared", v, 32'h0000_0004);

        // R6: reference strobe steps
        do_write(A_RLD, 32'd5);
        do_write(A_CTRL, 32'h1);
        for (int t = 0; t < 3; t++) begin
            ref_tick = 1'b1; @(negedge clk);
            ref_tick = 1'b0; @(negedge clk); @(negedge clk);
        end
        do_read(A_CUR, v); check("R6 strobe steps", v, 32'd2);

        // R8: stopped counter ignores strobes
        do_write(A_CTRL, 32'd0);
        for (int t = 0; t < 4; t++) begin
            ref_tick = 1'b1; @(negedge clk);
            ref_tick = 1'b0; @(negedge clk);
        end
        do_read(A_CUR, v); check("R8 frozen count", v, 32'd2);
        do_read(A_CTRL, v); check("R8 no flag", v, 32'd0);

        // R10: zero reload stops at zero
        do_write(A_CUR, 32'd0);
        do_write(A_RLD, 32'd2);
        do_write(A_CTRL, 32'h7);
        repeat (10) @(negedge clk);
        do_write(A_RLD, 32'd0);
        repeat (5) @(negedge clk);
        do_read(A_CTRL, v);
        for (int i = 1; i <= 8; i++) begin
            check("R10 no irq", {31'd0, irq}, 32'd0);
            @(negedge clk);
        end
        do_read(A_CUR, v);  check("R10 count held", v, 32'd0);
        do_read(A_CTRL, v); check("R10 no new flag", v, 32'h0000_0007);

        // R11: read in the wrap cycle sees the flag and it stays set
        do_write(A_CTRL, 32'd0);
        do_write(A_CUR, 32'd0);
        do_write(A_RLD, 32'd3);
        do_write(A_CTRL, 32'h5);
        @(negedge clk); @(negedge clk);
        do_read(A_CTRL, v); check("R11 read at wrap", v, 32'h0001_0005);
        do_write(A_CTRL, 32'd0);
        do_read(A_CTRL, v); check("R11 flag kept", v, 32'h0001_0000);

        // R12: reset while running
        do_write(A_CUR, 32'd0);
        do_write(A_CTRL, 32'h7);
        @(negedge clk); @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 irq held low", {31'd0, irq}, 32'd0);
        rst_n = 1'b1;
        do_read(A_CTRL, v); check("R12 ctrl after reset", v, 32'd0);
        do_read(A_RLD, v);  check("R12 reload after reset", v, 32'd0);
        do_read(A_CUR, v);  check("R12 count after reset", v, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule